// File: doc/BRIEF.md
# Four-Channel Counter/Timer with Vectored Interrupts

This block holds four independent 8-bit down-counting channels behind a small CPU register port. Each channel either counts system clocks through a prescaler (timer mode) or counts edges on its own trigger pin (counter mode). When a count runs out, the channel reloads its time constant, keeps counting and pulses its zero-count output for one cycle. The CPU can read any channel's live count at any time.

A channel with its interrupt enabled raises a request when it times out. One base vector is programmed for the whole block. The interrupt port is a valid/ready stream. `irq_valid` rises with `irq_vector` set to the base vector, with bits [2:1] replaced by the granted channel number and bit 0 cleared. While `irq_ready` is low, the valid flag and the vector are held unchanged, unless the CPU rewrites the base vector. A transfer, which is the acknowledge, happens on a clock edge where `irq_valid` and `irq_ready` are both high. After an acknowledge, `irq_valid` is low for at least one cycle before the next grant.

A write to a channel address is decoded as follows. If the channel is waiting for a time constant, the byte is the time constant. Otherwise, a byte with bit 0 set is a control word. A byte with bit 0 clear is the shared base vector, and any channel address accepts it.

Top module: `qct_top`

## Requirements
- R1: After reset, every channel reads count 0x00 and is stopped, `zc_out` is 0 and `irq_valid` is 0.
- R2: A control word has bit 0 set and carries these fields: bit 7 interrupt enable, bit 6 counter mode (0 = timer), bit 5 prescale by 256 (0 = by 16), bit 4 rising trigger edge (0 = falling), bit 3 timer waits for a trigger edge, bit 2 time constant follows, bit 1 stop channel. When bit 2 is set, the next write to that channel is the time constant. Writing the time constant loads both the reload value and the count.
- R3: In timer mode, without trigger start, the count decrements on the 16th clock edge after the time-constant write, or on the 256th edge when bit 5 is set, and again every 16 or 256 edges after that.
- R4: When a decrement would take the count from 1 to 0, the count reloads the time constant instead and the channel's `zc_out` bit is high for exactly one cycle. A time constant of 0 gives a period of 256 decrements.
- R5: In counter mode, the count decrements once per selected edge of the channel's `trg_in` pin. The opposite edge has no effect.
- R6: In timer mode with bit 3 set, the count holds after the time-constant write. The prescaler starts on the selected trigger edge, and the first decrement comes 16 (or 256) edges later, plus up to 4 cycles of input synchronisation.
- R7: `reg_rdata` shows the current count of the channel selected by `reg_addr`, combinationally.
- R8: `irq_vector` equals the base vector with bits [2:1] replaced by the channel number and bit 0 cleared.
- R9: While `irq_valid` is high and `irq_ready` is low, `irq_valid` and `irq_vector` stay unchanged. A new grant goes to the lowest-numbered pending channel.
- R10: A timeout with interrupt enable set leaves a request pending until it is acknowledged. With interrupt enable clear, a timeout raises no request.
- R11: A control word with bit 1 set stops the channel. The count freezes, and any pending request is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Channel select for writes and reads |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Current count of the selected channel |
| trg_in | input | 4 | Per-channel clock/trigger pins |
| zc_out | output | 4 | Per-channel one-cycle zero-count pulse |
| irq_valid | output | 1 | Interrupt request granted, vector valid |
| irq_ready | input | 1 | CPU acknowledge of the current vector |
| irq_vector | output | 8 | Vector of the granted channel |

## Verification
A wrong prescaler or reload value shows up as a `zc_out` pulse at the wrong clock count, so every timing check measures the exact edge count from the configuring write. That makes an off-by-one error visible on the first period. A corrupted live count shows on `reg_rdata` within one decrement period, and a mis-decoded control field changes either the period or the edge that decrements. An arbitration or pending-state fault shows on the interrupt stream at the next grant, which comes one cycle after an acknowledge. The vector sequence seen while several requests wait therefore exposes it within a few cycles.

// File: rtl/qct_pkg.sv
package qct_pkg;
  // control word bit positions (decoded by the channel and the top)
  localparam int B_CTL  = 0;
  localparam int B_STOP = 1;
  localparam int B_TCF  = 2;
  localparam int B_TRG  = 3;
  localparam int B_RISE = 4;
  localparam int B_DIV  = 5;
  localparam int B_CNT  = 6;
  localparam int B_IE   = 7;

  typedef struct packed {
    logic irq_en;
    logic cnt_mode;
    logic div_long;
    logic rise;
    logic trig_start;
  } qct_cfg_t;
endpackage

// File: rtl/qct_edge_det.sv
module qct_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic rise_sel_i,
  output logic edge_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   cur;

  assign cur = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_q <= cur;
    end
  end

  assign edge_o = rise_sel_i ? (cur & ~prev_q) : (~cur & prev_q);

  AST_EDGE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o && $stable(rise_sel_i) |=> !edge_o); // R5
endmodule

// File: rtl/qct_prescaler.sv
module qct_prescaler #(
  parameter int PW         = 8,
  parameter int SHORT_BITS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic clear_i,
  input  logic long_i,
  output logic tick_o
);
  logic [PW-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pre_q <= '0;
    else if (clear_i || !run_i) pre_q <= '0;
    else                        pre_q <= pre_q + 1'b1;
  end

  assign tick_o = run_i && !clear_i &&
                  (long_i ? (&pre_q) : (&pre_q[SHORT_BITS-1:0]));

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o); // R3
endmodule

// File: rtl/qct_channel.sv
module qct_channel
  import qct_pkg::*;
#(
  parameter int W          = 8,
  parameter int SHORT_BITS = 4,
  parameter int SYNC       = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctl_we_i,
  input  logic         tc_we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         trg_pin_i,
  output logic [W-1:0] count_o,
  output logic         zc_o,
  output logic         irq_set_o,
  output logic         tc_wait_o
);
  qct_cfg_t     cfg_q;
  logic [W-1:0] tc_q, count_q;
  logic         running_q, armed_q, tc_wait_q, zc_q;
  logic         trg_edge, tick, dec;

  qct_edge_det #(.SYNC_STAGES(SYNC)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin_i(trg_pin_i),
    .rise_sel_i(cfg_q.rise), .edge_o(trg_edge)
  );

  qct_prescaler #(.PW(W), .SHORT_BITS(SHORT_BITS)) u_pre (
    .clk(clk), .rst_n(rst_n), .run_i(running_q && !cfg_q.cnt_mode),
    .clear_i(tc_we_i), .long_i(cfg_q.div_long), .tick_o(tick)
  );

  assign dec = running_q && !tc_we_i && (cfg_q.cnt_mode ? trg_edge : tick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      tc_q      <= '0;
      count_q   <= '0;
      running_q <= 1'b0;
      armed_q   <= 1'b0;
      tc_wait_q <= 1'b0;
      zc_q      <= 1'b0;
    end else begin
      zc_q <= dec && (count_q == W'(1));
      if (ctl_we_i) begin
        cfg_q.irq_en     <= wdata_i[B_IE];
        cfg_q.cnt_mode   <= wdata_i[B_CNT];
        cfg_q.div_long   <= wdata_i[B_DIV];
        cfg_q.rise       <= wdata_i[B_RISE];
        cfg_q.trig_start <= wdata_i[B_TRG];
        tc_wait_q        <= wdata_i[B_TCF];
        if (wdata_i[B_STOP]) begin
          running_q <= 1'b0;
          armed_q   <= 1'b0;
        end
      end
      if (tc_we_i) begin
        tc_q      <= wdata_i;
        count_q   <= wdata_i;
        tc_wait_q <= 1'b0;
        if (!cfg_q.cnt_mode && cfg_q.trig_start) begin
          armed_q   <= 1'b1;
          running_q <= 1'b0;
        end else begin
          armed_q   <= 1'b0;
          running_q <= 1'b1;
        end
      end else if (armed_q && trg_edge && !ctl_we_i) begin
        armed_q   <= 1'b0;
        running_q <= 1'b1;
      end else if (dec && !(ctl_we_i && wdata_i[B_STOP])) begin
        count_q <= (count_q == W'(1)) ? tc_q : count_q - 1'b1;
      end
    end
  end

  assign count_o   = count_q;
  assign zc_o      = zc_q;
  assign irq_set_o = zc_q && cfg_q.irq_en;
  assign tc_wait_o = tc_wait_q;

  AST_ZC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    zc_o |=> !zc_o); // R4
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!running_q && !tc_we_i) |=> $stable(count_o)); // R11
endmodule

// File: rtl/qct_irq_arb.sv
module qct_irq_arb #(
  parameter int NCH = 4,
  parameter int W   = 8,
  localparam int AW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set_i,
  input  logic           base_we_i,
  input  logic [W-1:0]   base_i,
  input  logic           irq_ready_i,
  output logic           irq_valid_o,
  output logic [W-1:0]   irq_vector_o
);
  logic [NCH-1:0]  pending_q, ack_mask;
  logic [W-1:AW+1] base_q;
  logic            grant_v_q;
  logic [AW-1:0]   grant_id_q, pick;
  logic            ack;

  assign ack = grant_v_q && irq_ready_i;

  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (pending_q[i]) pick = AW'(i);
  end

  always_comb begin
    ack_mask = '0;
    if (ack) ack_mask[grant_id_q] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q  <= '0;
      base_q     <= '0;
      grant_v_q  <= 1'b0;
      grant_id_q <= '0;
    end else begin
      pending_q <= (pending_q & ~ack_mask) | set_i;
      if (base_we_i) base_q <= base_i[W-1:AW+1];
      if (ack) begin
        grant_v_q <= 1'b0;
      end else if (!grant_v_q && (|pending_q)) begin
        grant_v_q  <= 1'b1;
        grant_id_q <= pick;
      end
    end
  end

  assign irq_valid_o  = grant_v_q;
  assign irq_vector_o = {base_q, grant_id_q, 1'b0};

  AST_HOLD_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_o && !irq_ready_i && !base_we_i) |=> (irq_valid_o && $stable(irq_vector_o))); // R9
  AST_GRANT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> pending_q[grant_id_q]); // R10
endmodule

// File: rtl/qct_top.sv
module qct_top
  import qct_pkg::*;
#(
  parameter int NCH        = 4,
  parameter int W          = 8,
  parameter int SHORT_BITS = 4,
  parameter int SYNC       = 2,
  localparam int AW        = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [AW-1:0]  reg_addr,
  input  logic [W-1:0]   reg_wdata,
  output logic [W-1:0]   reg_rdata,
  input  logic [NCH-1:0] trg_in,
  output logic [NCH-1:0] zc_out,
  output logic           irq_valid,
  input  logic           irq_ready,
  output logic [W-1:0]   irq_vector
);
  logic [NCH-1:0]        ctl_we, tc_we, irq_set, tc_wait;
  logic [NCH-1:0][W-1:0] count;
  logic                  base_we;

  always_comb begin
    ctl_we  = '0;
    tc_we   = '0;
    base_we = 1'b0;
    if (reg_wr) begin
      if (tc_wait[reg_addr])          tc_we[reg_addr]  = 1'b1;
      else if (reg_wdata[B_CTL])      ctl_we[reg_addr] = 1'b1;
      else                            base_we          = 1'b1;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    qct_channel #(.W(W), .SHORT_BITS(SHORT_BITS), .SYNC(SYNC)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .ctl_we_i(ctl_we[c]), .tc_we_i(tc_we[c]), .wdata_i(reg_wdata),
      .trg_pin_i(trg_in[c]),
      .count_o(count[c]), .zc_o(zc_out[c]),
      .irq_set_o(irq_set[c]), .tc_wait_o(tc_wait[c])
    );
  end

  assign reg_rdata = count[reg_addr];

  qct_irq_arb #(.NCH(NCH), .W(W)) u_arb (
    .clk(clk), .rst_n(rst_n), .set_i(irq_set),
    .base_we_i(base_we), .base_i(reg_wdata),
    .irq_ready_i(irq_ready), .irq_valid_o(irq_valid),
    .irq_vector_o(irq_vector)
  );

  AST_ONE_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ctl_we, tc_we, base_we}) <= 1); // R2
endmodule

// File: tb/qct_top_tb_top.sv
module qct_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [3:0] trg_in = '0;
  logic [3:0] zc_out;
  logic       irq_valid;
  logic       irq_ready = 1'b0;
  logic [7:0] irq_vector;

  int checks = 0;
  int failures = 0;
  logic [3:0] zc_seen;

  always #(CLK_PERIOD/2) clk = ~clk;

  qct_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trg_in(trg_in),
    .zc_out(zc_out), .irq_valid(irq_valid), .irq_ready(irq_ready),
    .irq_vector(irq_vector)
  );

  always @(negedge clk) zc_seen <= zc_seen | zc_out;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; trg_in = '0; irq_ready = 1'b0; reg_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    zc_seen = '0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    reg_addr = a; #1 v = reg_rdata;
  endtask

  // negedges until zc_out[ch] is seen, counted from the edge that took the last write
  task automatic wait_zc(input int ch, input int maxn, output int n);
    n = 0;
    while (n < maxn) begin
      @(negedge clk); n++;
      if (zc_out[ch]) return;
    end
    n = -1;
  endtask

  task automatic t_reset();
    int v;
    do_reset();
    for (int c = 0; c < 4; c++) begin
      rd(c[1:0], v);
      check(v == 0, "R1 count after reset", v, 0);
    end
    check(zc_out == 0 && irq_valid == 0, "R1 outputs idle", {zc_out, irq_valid}, 0);
  endtask

  task automatic t_timer16();
    int n;
    do_reset();
    wr(0, 8'h05); wr(0, 8'd3);
    wait_zc(0, 200, n);
    check(n == 48, "R3 first timeout div16 tc3", n, 48);
    @(negedge clk);
    check(zc_out[0] == 0, "R4 zc one cycle", zc_out[0], 0);
    wait_zc(0, 200, n);
    check(n == 47, "R4 reload period", n + 1, 48);
  endtask

  task automatic t_timer256();
    int n, v;
    do_reset();
    wr(1, 8'h25); wr(1, 8'd2);
    repeat (300) @(negedge clk);
    rd(1, v);
    check(v == 1, "R3 div256 readback", v, 1);
    wait_zc(1, 400, n);
    check(n == 212, "R3 div256 timeout", n + 300, 512);
  endtask

  task automatic t_tc_zero();
    int n;
    do_reset();
    wr(2, 8'h05); wr(2, 8'd0);
    wait_zc(2, 5000, n);
    check(n == 4096, "R4 tc 0 means 256", n, 4096);
  endtask

  task automatic t_counter();
    int v;
    do_reset();
    wr(2, 8'h55); wr(2, 8'd3);
    for (int p = 1; p <= 2; p++) begin
      trg_in[2] = 1'b1; repeat (5) @(negedge clk);
      trg_in[2] = 1'b0; repeat (5) @(negedge clk);
      rd(2, v);
      check(v == 3 - p, "R5 rising edge count", v, 3 - p);
    end
    zc_seen = '0;
    trg_in[2] = 1'b1; repeat (5) @(negedge clk);
    trg_in[2] = 1'b0; repeat (5) @(negedge clk);
    rd(2, v);
    check(zc_seen[2] && v == 3, "R4 counter reload", v, 3);
    // falling edge selected
    wr(3, 8'h45); wr(3, 8'd3);
    trg_in[3] = 1'b1; repeat (5) @(negedge clk);
    rd(3, v);
    check(v == 3, "R5 opposite edge ignored", v, 3);
    trg_in[3] = 1'b0; repeat (5) @(negedge clk);
    rd(3, v);
    check(v == 2, "R5 falling edge count", v, 2);
  endtask

  task automatic t_trigger();
    int n, v;
    do_reset();
    wr(1, 8'h1D); wr(1, 8'd4);
    repeat (40) @(negedge clk);
    rd(1, v);
    check(v == 4, "R6 holds until trigger", v, 4);
    trg_in[1] = 1'b1;
    wait_zc(1, 200, n);
    check(n >= 64 && n <= 68, "R6 start on trigger", n, 64);
  endtask

  task automatic t_stop();
    int v;
    do_reset();
    wr(0, 8'h85); wr(0, 8'd10);
    repeat (38) @(negedge clk);
    rd(0, v);
    check(v == 8, "R7 live readback", v, 8);
    wr(0, 8'h83);
    repeat (60) @(negedge clk);
    rd(0, v);
    check(v == 8, "R11 stop freezes count", v, 8);
  endtask

  task automatic t_no_irq();
    int n;
    do_reset();
    wr(2, 8'h05); wr(2, 8'd2);
    wait_zc(2, 100, n);
    repeat (4) @(negedge clk);
    check(n == 32 && irq_valid == 0, "R10 disabled irq silent", irq_valid, 0);
  endtask

  task automatic t_irq();
    do_reset();
    wr(0, 8'hA6);
    wr(3, 8'h85); wr(3, 8'd1);
    wr(1, 8'h85); wr(1, 8'd1);
    wr(0, 8'h85); wr(0, 8'd1);
    repeat (40) @(negedge clk);
    wr(3, 8'h83); wr(1, 8'h83); wr(0, 8'h83);
    check(irq_valid && irq_vector == 8'hA6, "R8 first vector ch3", irq_vector, 8'hA6);
    repeat (60) @(negedge clk);
    check(irq_valid && irq_vector == 8'hA6, "R10 pending held", irq_vector, 8'hA6);
    irq_ready = 1'b1; @(negedge clk); irq_ready = 1'b0;
    check(!irq_valid, "R9 valid drops after ack", irq_valid, 0);
    @(negedge clk);
    check(irq_valid && irq_vector == 8'hA0, "R9 priority ch0", irq_vector, 8'hA0);
    irq_ready = 1'b1; @(negedge clk); irq_ready = 1'b0; @(negedge clk);
    check(irq_valid && irq_vector == 8'hA2, "R8 vector ch1", irq_vector, 8'hA2);
    irq_ready = 1'b1; @(negedge clk); irq_ready = 1'b0; repeat (3) @(negedge clk);
    check(!irq_valid, "R10 all acknowledged", irq_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_timer16();
    t_timer256();
    t_tc_zero();
    t_counter();
    t_trigger();
    t_stop();
    t_no_irq();
    t_irq();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule